// File: doc/BRIEF.md
# Interrupt Request and Vector Core

This block is the decision core of an eight-line interrupt controller. Each request input is watched for a low-to-high change. A change on a line whose mask bit is clear is recorded in a request register. A change on a masked line is thrown away. The core raises a one-cycle interrupt pulse toward the processor when the request may be served. A request may be served when no in-service line at the same or a higher number is active. Higher line numbers have higher priority.

When the processor acknowledges, the core picks the highest-numbered pending request and removes it from the request register. It then either marks that line in service or, in automatic end-of-interrupt mode, retires it at once. It returns a vector made from the aligned vector base with the line number in its low bits. If the cascade map marks the chosen line, the core raises a flag telling the system that a downstream controller must supply the vector. An end-of-interrupt strobe from the command side clears one in-service bit. After that, the highest pending request is checked again and may produce a new pulse. The mask, vector base, automatic end-of-interrupt enable and cascade map are plain configuration inputs.

Top module: `irq_vector_core`

## Requirements
- R1: A request is taken only on a cycle where the input is 1 and was 0 at the previous clock edge. A level held high creates no further request. All lines read as 0 at reset.
- R2: A new request on a line whose `mask_in` bit is 1 leaves `req_o` unchanged and produces no pulse.
- R3: A new request on an unmasked line sets bit `line` of `req_o` on the next clock edge.
- R4: `int_pulse_o` is high for exactly one cycle after an unmasked new request on line L, but only when `isr_o` has no bit set at positions L and above.
- R5: An acknowledge with requests pending has the following effects, visible one cycle later:
  - `vector_valid_o` is high.
  - The highest-numbered set bit of `req_o` is cleared.
  - `vector_o` equals `vec_base_in` with its low 3 bits forced to 0, ORed with that line number.
- R6: With `auto_eoi_in` at 0, an acknowledge sets the `isr_o` bit of the selected line.
- R7: With `auto_eoi_in` at 1, an acknowledge leaves `isr_o` unchanged. If requests remain and none is blocked under R4, `int_pulse_o` pulses.
- R8: `slave_vec_o` is 1 with the vector exactly when `cascade_map_in` bit of the selected line is 1.
- R9: An end-of-interrupt strobe clears `isr_o` bit `eoi_line_in`. If requests then remain, the highest one pulses `int_pulse_o` when it is not blocked under R4.
- R10: An acknowledge with `req_o` equal to 0 has the following effects:
  - It returns the aligned base as the vector.
  - `slave_vec_o` is 0.
  - `req_o` and `isr_o` are not changed.
- R11: After reset, `req_o`, `isr_o`, `int_pulse_o`, `vector_valid_o`, `slave_vec_o` and `vector_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Raw request levels, one per line |
| mask_in | input | 8 | A 1 discards new requests on that line |
| vec_base_in | input | 8 | Vector base; low 3 bits ignored |
| auto_eoi_in | input | 1 | Retire the line at acknowledge instead of marking it in service |
| cascade_map_in | input | 8 | A 1 marks a line fed by a downstream controller |
| ack_in | input | 1 | One-cycle acknowledge strobe |
| eoi_in | input | 1 | One-cycle end-of-interrupt strobe |
| eoi_line_in | input | 3 | Line retired by `eoi_in` |
| int_pulse_o | output | 1 | One-cycle interrupt pulse |
| vector_o | output | 8 | Vector from the last acknowledge |
| vector_valid_o | output | 1 | High the cycle after an acknowledge |
| slave_vec_o | output | 1 | Downstream controller must supply the vector |
| req_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |

## Verification
The bench runs each line on its own, raising it, holding it, acknowledging it and ending it. This separates edge detection from level sensing and proves that each line reaches its own vector. It tries every ordered pair of an in-service line and a requesting line. That sweep pins the at-or-above blocking rule, as opposed to a strictly-above or priority-ignoring one, and shows that the blocked request is released by the later end-of-interrupt. Further runs cover the following:
- mixed multi-line patterns, to show descending service order;
- masked lines;
- automatic end-of-interrupt;
- cascade flags;
- empty acknowledges with a misaligned base.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    // Outcome of an acknowledge in the current cycle
    typedef enum logic [1:0] {
        ACK_IDLE    = 2'd0,
        ACK_EMPTY   = 2'd1,
        ACK_LOCAL   = 2'd2,
        ACK_CASCADE = 2'd3
    } ack_kind_e;

endpackage

// File: rtl/irqv_edge.sv
module irqv_edge #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lvl_i,
    output logic [NUM_LINES-1:0] rise_o
);

    logic [NUM_LINES-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/irqv_prio.sv
// Highest-numbered set bit finder
module irqv_prio #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_LINES-1:0] vec_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |vec_i;

endmodule

// File: rtl/irqv_clear_check.sv
// clear_o is 1 when no in-service bit sits at or above line_i
module irqv_clear_check #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_LINES-1:0] isr_i,
    input  logic [IDX_W-1:0]     line_i,
    output logic                 clear_o
);

    logic [NUM_LINES-1:0] busy;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_busy
        assign busy[g] = isr_i[g] & (line_i <= IDX_W'(g));
    end

    assign clear_o = ~|busy;

endmodule

// File: rtl/irq_vector_core.sv
module irq_vector_core
    import irqv_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int VEC_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] mask_in,
    input  logic [VEC_W-1:0]     vec_base_in,
    input  logic                 auto_eoi_in,
    input  logic [NUM_LINES-1:0] cascade_map_in,
    input  logic                 ack_in,
    input  logic                 eoi_in,
    input  logic [((NUM_LINES > 1) ? $clog2(NUM_LINES) : 1)-1:0] eoi_line_in,
    output logic                 int_pulse_o,
    output logic [VEC_W-1:0]     vector_o,
    output logic                 vector_valid_o,
    output logic                 slave_vec_o,
    output logic [NUM_LINES-1:0] req_o,
    output logic [NUM_LINES-1:0] isr_o
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [VEC_W-1:0] LOW_MASK = VEC_W'((1 << IDX_W) - 1);

    typedef struct packed {
        logic [NUM_LINES-1:0] req;
        logic [NUM_LINES-1:0] isr;
        logic                 pulse;
        logic [VEC_W-1:0]     vec;
        logic                 vec_valid;
        logic                 slave;
    } core_state_t;

    core_state_t s_d, s_q;

    // ---------------- edge detection and new-request qualification
    logic [NUM_LINES-1:0] rise, accepted, line_clear;
    logic                 rise_fire;

    irqv_edge #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (irq_in),
        .rise_o (rise)
    );

    assign accepted = rise & ~mask_in;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_rise_chk
        irqv_clear_check #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
            .isr_i   (s_q.isr),
            .line_i  (IDX_W'(g)),
            .clear_o (line_clear[g])
        );
    end

    assign rise_fire = |(accepted & line_clear);

    // ---------------- acknowledge selection
    logic             ack_any;
    logic [IDX_W-1:0] ack_idx;

    irqv_prio #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ack_sel (
        .vec_i (s_q.req),
        .any_o (ack_any),
        .idx_o (ack_idx)
    );

    logic [VEC_W-1:0] base_aligned, ack_vec;
    assign base_aligned = vec_base_in & ~LOW_MASK;
    assign ack_vec      = base_aligned | VEC_W'(ack_idx);

    // ---------------- register updates from ack, eoi and new requests
    logic [NUM_LINES-1:0] req_nx, isr_nx;
    logic                 reeval;
    ack_kind_e            ack_kind;

    always_comb begin
        req_nx   = s_q.req;
        isr_nx   = s_q.isr;
        reeval   = 1'b0;
        ack_kind = ACK_IDLE;
        if (ack_in) begin
            if (ack_any) begin
                req_nx[ack_idx] = 1'b0;
                ack_kind = cascade_map_in[ack_idx] ? ACK_CASCADE : ACK_LOCAL;
                if (auto_eoi_in) reeval = 1'b1;
                else             isr_nx[ack_idx] = 1'b1;
            end else begin
                ack_kind = ACK_EMPTY;
            end
        end
        if (eoi_in) begin
            isr_nx[eoi_line_in] = 1'b0;
            reeval = 1'b1;
        end
        req_nx = req_nx | accepted;
    end

    // ---------------- re-evaluation after a retired line
    logic             top_any, top_clear;
    logic [IDX_W-1:0] top_idx;

    irqv_prio #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_top_sel (
        .vec_i (req_nx),
        .any_o (top_any),
        .idx_o (top_idx)
    );

    irqv_clear_check #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_top_chk (
        .isr_i   (isr_nx),
        .line_i  (top_idx),
        .clear_o (top_clear)
    );

    // ---------------- next state
    always_comb begin
        s_d           = s_q;
        s_d.req       = req_nx;
        s_d.isr       = isr_nx;
        s_d.pulse     = rise_fire | (reeval & top_any & top_clear);
        s_d.vec_valid = (ack_kind != ACK_IDLE);
        case (ack_kind)
            ACK_EMPTY: begin
                s_d.vec   = base_aligned;
                s_d.slave = 1'b0;
            end
            ACK_LOCAL: begin
                s_d.vec   = ack_vec;
                s_d.slave = 1'b0;
            end
            ACK_CASCADE: begin
                s_d.vec   = ack_vec;
                s_d.slave = 1'b1;
            end
            default: begin
                s_d.vec   = s_q.vec;
                s_d.slave = s_q.slave;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign int_pulse_o    = s_q.pulse;
    assign vector_o       = s_q.vec;
    assign vector_valid_o = s_q.vec_valid;
    assign slave_vec_o    = s_q.slave;
    assign req_o          = s_q.req;
    assign isr_o          = s_q.isr;

    // ---------------- assertions
    p_no_masked_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_o & ~$past(req_o)) & $past(mask_in)) == '0);

    p_valid_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in |=> vector_valid_o);

    p_isr_marked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && !auto_eoi_in && !eoi_in && req_o != '0) |=> isr_o[vector_o[IDX_W-1:0]]);

    p_auto_keeps_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && auto_eoi_in && !eoi_in) |=> isr_o == $past(isr_o));

    p_eoi_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_in && !ack_in) |=> !isr_o[$past(eoi_line_in)]);

    p_empty_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && req_o == '0) |=> ((vector_o & LOW_MASK) == '0 && !slave_vec_o));

endmodule

// File: tb/irq_vector_core_tb_top.sv
`timescale 1ns/1ps
module irq_vector_core_tb_top;

    localparam int N  = 8;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq = '0, mask = '0, cmap = '0;
    logic [VW-1:0] base = '0;
    logic          auto_e = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic [2:0]    eoi_line = '0;
    logic          pulse_o, valid_o, slave_o;
    logic [VW-1:0] vec_o;
    logic [N-1:0]  req_o, isr_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [N-1:0] m_prev = '0, m_req = '0, m_isr = '0;

    always #2.5 clk = ~clk;

    irq_vector_core #(.NUM_LINES(N), .VEC_W(VW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_in         (irq),
        .mask_in        (mask),
        .vec_base_in    (base),
        .auto_eoi_in    (auto_e),
        .cascade_map_in (cmap),
        .ack_in         (ack),
        .eoi_in         (eoi),
        .eoi_line_in    (eoi_line),
        .int_pulse_o    (pulse_o),
        .vector_o       (vec_o),
        .vector_valid_o (valid_o),
        .slave_vec_o    (slave_o),
        .req_o          (req_o),
        .isr_o          (isr_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int top_bit(input logic [N-1:0] v);
        int r = 0;
        for (int i = 0; i < N; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic blocked(input logic [N-1:0] s, input int line);
        return (s >> line) != '0;
    endfunction

    // One clock with the expected outcome worked out from the requirements
    task automatic step();
        logic [N-1:0]  rise, acc, rq, is;
        logic          e_pulse, e_valid, e_slave, rev;
        logic [VW-1:0] e_vec;
        int sel;
        rise = irq & ~m_prev;
        acc  = rise & ~mask;
        e_pulse = 1'b0;
        for (int l = 0; l < N; l++) if (acc[l] && !blocked(m_isr, l)) e_pulse = 1'b1;
        rq = m_req; is = m_isr; rev = 1'b0;
        e_valid = ack; e_slave = 1'b0; e_vec = base & ~VW'(7);
        if (ack && m_req != '0) begin
            sel = top_bit(m_req);
            rq[sel] = 1'b0;
            e_vec = (base & ~VW'(7)) | VW'(sel);
            e_slave = cmap[sel];
            if (auto_e) rev = 1'b1;
            else        is[sel] = 1'b1;
        end
        if (eoi) begin
            is[eoi_line] = 1'b0;
            rev = 1'b1;
        end
        rq = rq | acc;
        if (rev && rq != '0 && !blocked(is, top_bit(rq))) e_pulse = 1'b1;
        m_prev = irq; m_req = rq; m_isr = is;
        @(posedge clk);
        #1;
        check("R4 pulse", 32'(pulse_o), 32'(e_pulse));
        check("R3 request reg", 32'(req_o), 32'(rq));
        check("R6 in-service reg", 32'(isr_o), 32'(is));
        check("R5 valid", 32'(valid_o), 32'(e_valid));
        if (e_valid) begin
            check("R5 vector", 32'(vec_o), 32'(e_vec));
            check("R8 slave flag", 32'(slave_o), 32'(e_slave));
        end
        ack = 1'b0; eoi = 1'b0;
    endtask

    task automatic raise(input int l); irq[l] = 1'b1; step(); endtask
    task automatic drop(input int l);  irq[l] = 1'b0; step(); endtask
    task automatic do_ack();           ack = 1'b1; step(); endtask
    task automatic do_eoi(input int l); eoi = 1'b1; eoi_line = 3'(l); step(); endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11 req", 32'(req_o), 0);
        check("R11 isr", 32'(isr_o), 0);
        check("R11 outs", {29'd0, pulse_o, valid_o, slave_o}, 0);
        check("R11 vector", 32'(vec_o), 0);
        rst_n = 1'b1;
        step();

        // Per-line walk
        for (int l = 0; l < N; l++) begin
            base = 8'h40 + VW'(l << 3);
            raise(l);
            check("R3 line set", 32'(req_o), 32'(1 << l));
            step();
            check("R1 held level no pulse", 32'(pulse_o), 0);
            do_ack();
            check("R5 own vector", 32'(vec_o), 32'(base | VW'(l)));
            drop(l);
            do_eoi(l);
            check("R9 cleared", 32'(isr_o), 0);
        end

        // Masked lines
        for (int l = 0; l < N; l++) begin
            mask = N'(1 << l);
            raise(l);
            check("R2 masked req", 32'(req_o), 0);
            check("R2 masked pulse", 32'(pulse_o), 0);
            drop(l);
            mask = '0;
            step();
        end

        // Blocking sweep over in-service / requesting pairs
        base = 8'h20;
        for (int s = 0; s < N; s++) begin
            for (int l = 0; l < N; l++) begin
                if (l != s) begin
                    raise(s); do_ack(); drop(s);
                    raise(l);
                    check("R4 block rule", 32'(pulse_o), 32'(l > s));
                    drop(l);
                    do_eoi(s);
                    do_ack();
                    do_eoi(l);
                end
            end
        end

        // Multi-line pattern served in descending order
        irq = 8'hA5; step();
        do_ack(); check("R5 order 7", 32'(vec_o), 32'h27);
        do_ack(); check("R5 order 5", 32'(vec_o), 32'h25);
        do_ack(); check("R5 order 2", 32'(vec_o), 32'h22);
        do_ack(); check("R5 order 0", 32'(vec_o), 32'h20);
        irq = '0; step();
        for (int l = 0; l < N; l++) do_eoi(l);

        // Automatic end-of-interrupt
        auto_e = 1'b1;
        irq = 8'h48; step();
        do_ack();
        check("R7 isr untouched", 32'(isr_o), 0);
        check("R7 re-signal", 32'(pulse_o), 1);
        do_ack();
        check("R7 last served no pulse", 32'(pulse_o), 0);
        irq = '0; step();
        auto_e = 1'b0;

        // Cascade flag
        cmap = 8'h04;
        raise(2); do_ack();
        check("R8 cascade line", 32'(slave_o), 1);
        drop(2); do_eoi(2);
        raise(5); do_ack();
        check("R8 own line", 32'(slave_o), 0);
        drop(5); do_eoi(5);
        cmap = '0;

        // Empty acknowledge with misaligned base
        base = 8'h57;
        do_ack();
        check("R10 empty vector", 32'(vec_o), 32'h50);
        check("R10 empty regs", {16'd0, req_o, isr_o}, 0);
        raise(1); do_ack(); do_ack();
        check("R10 empty after drain", 32'(vec_o), 32'h50);
        check("R10 isr kept", 32'(isr_o), 32'h02);
        drop(1); do_eoi(1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule